// File: doc/BRIEF.md
# Raster-Synchronised Display List Coprocessor

This block walks a list of two-word instructions held in word-addressed memory and acts on them in step with the beam. Three kinds of instruction exist. A register store sends a 16-bit value to a chipset register through a write master port. A beam wait stalls the list until the beam position, seen through a per-instruction mask, reaches a compare value. A conditional skip tests the same kind of condition once and, when it holds, suppresses the store that follows.

The engine owns only the memory slots that the arbiter grants to it (every other slot in the intended system) and uses one granted slot per word fetched. Two list start pointers, a guard control bit and two restart strobes are reached through a small configuration port. A frame-start pulse restarts the first list. Two DMA enable inputs gate the whole engine. When stopped or waiting, it requests no memory.

Top module: `dlist_engine`

## Requirements
- R1: An instruction whose first word has bit 0 clear is a store. Its register address is first word AND 0x1FE, and its data is the second word. `rw_valid` pulses for one cycle, in the cycle after the granted slot that fetches the second word. Each fetch uses one granted cycle with `mem_req` high, and `mem_addr` rises by one after each fetch.
- R2: An instruction with bit 0 set in the first word and bit 0 clear in the second word is a wait. Mask = 0x8001 OR (second word AND 0x7FFE), and compare value = first word AND mask. The engine holds, with `mem_req` low, until a granted cycle sees (position AND mask) >= compare value. It then fetches the next instruction.
- R3: The position word is {beam_v[7:0], beam_hc[6:0], 0}. Bits 15 and 0 are always part of the compare, whatever the mask field holds. Because bit 0 of the position is zero, a compare value that matches the unmasked beam exactly does not release a wait.
- R4: An instruction with bit 0 set in both words is a skip. It records whether (position AND mask) >= compare value. When the record is true, the next store is fetched but not performed. The fetch of any second word consumes the record.
- R5: A store to a register address below 0x10 stops the engine. A store to an address below 0x20 also stops it, unless the guard bit (bit 0 of the word written at configuration offset 0x02E) is 1. A stopped engine performs no write and no further fetch.
- R6: Configuration writes to 0x080/0x082 set the high and low halves of list pointer 1, and writes to 0x084/0x086 set those of list pointer 2. Any access, read or write, to 0x088 or 0x08A restarts fetching at list 1 or list 2 on the next cycle.
- R7: A `frame_start` pulse restarts fetching at list 1. A restart strobe in the same cycle takes priority and selects its own list.
- R8: The engine runs only while `master_dma_en` and `list_dma_en` are both 1. Otherwise it is stopped at the next edge and restarts are ignored. It stays stopped when the enables return, until the next restart.
- R9: A restart discards a pending skip record.
- R10: After reset the engine is stopped, with `mem_req` and `rw_valid` low, both pointers zero and the guard bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_dma_en | input | 1 | Global DMA enable |
| list_dma_en | input | 1 | Enable for this engine's DMA |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| beam_v | input | 8 | Vertical beam position, low 8 bits |
| beam_hc | input | 7 | Horizontal beam position bits 7..1 |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 for a write access, 0 for a read access |
| cfg_addr | input | 9 | Configuration byte offset |
| cfg_wdata | input | 16 | Configuration write data |
| slot_grant | input | 1 | Memory slot granted to this engine in this cycle |
| mem_req | output | 1 | The engine wants to fetch a word |
| mem_addr | output | ADDR_W | Word address of the fetch |
| mem_rdata | input | 16 | Fetched word, valid in the same cycle |
| rw_valid | output | 1 | Register write strobe |
| rw_addr | output | 9 | Register byte address |
| rw_data | output | 16 | Register write data |

## Verification
Store lists are run with addresses that carry stray upper bits, so the tests show whether the address is masked and whether the order is kept. Waits are released by raising the vertical position in steps: just below, exactly at and just past the compare value. This separates a correct >= on the masked word from a compare on the raw beam and from a compare that drops the fixed bits. Skips are driven with the condition true and with it false, and once with a restart placed between the skip and its target. This tells a consumed record apart from one that leaks across a restart. Stores just below each guard limit are run with the guard bit in both states, and the disable, strobe and frame tests show which restart source wins and that a forced stop is sticky.

// File: rtl/dle_pkg.sv
package dle_pkg;
   localparam int WORD_W = 16;
   localparam int REG_AW = 9;

   localparam logic [REG_AW-1:0] OFF_CTRL     = 9'h02E;
   localparam logic [REG_AW-1:0] OFF_PTR_BASE = 9'h080;
   localparam logic [REG_AW-1:0] OFF_RST0     = 9'h088;
   localparam logic [REG_AW-1:0] OFF_RST1     = 9'h08A;

   localparam logic [WORD_W-1:0] FIXED_CMP_BITS = 16'h8001;
   localparam logic [WORD_W-1:0] MASK_FIELD     = 16'h7FFE;
   localparam logic [REG_AW-1:0] REG_ALIGN      = 9'h1FE;

   typedef enum logic [1:0] {
      ST_STOP    = 2'd0,
      ST_WAIT    = 2'd1,
      ST_FETCH_A = 2'd2,
      ST_FETCH_B = 2'd3
   } dle_state_e;
endpackage

// File: rtl/dle_beam_cmp.sv
module dle_beam_cmp
   import dle_pkg::*;
(
   input  logic [WORD_W-1:0] pos,
   input  logic [WORD_W-1:0] mask,
   input  logic [WORD_W-1:0] ref_val,
   output logic              reached
);
   always_comb reached = (pos & mask) >= ref_val;
endmodule

// File: rtl/dle_cfg_regs.sv
module dle_cfg_regs
   import dle_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_valid,
   input  logic                       cfg_write,
   input  logic [REG_AW-1:0]          cfg_addr,
   input  logic [WORD_W-1:0]          cfg_wdata,
   output logic                       guard_off,
   output logic [1:0][ADDR_W-1:0]     list_ptr,
   output logic                       strobe,
   output logic                       strobe_sel
);
   localparam int HI_W = ADDR_W - WORD_W;

   logic [REG_AW-1:0] a;
   logic              wr;
   assign a  = cfg_addr & REG_ALIGN;
   assign wr = cfg_valid && cfg_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         guard_off <= 1'b0;
      else if (wr && a == OFF_CTRL)
         guard_off <= cfg_wdata[0];
   end

   for (genvar i = 0; i < 2; i++) begin : g_ptr
      localparam logic [REG_AW-1:0] OFF_HI = OFF_PTR_BASE + REG_AW'(4 * i);
      localparam logic [REG_AW-1:0] OFF_LO = OFF_HI + REG_AW'(2);
      logic [ADDR_W-1:0] ptr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ptr_q <= '0;
         else if (wr && a == OFF_HI)
            ptr_q[ADDR_W-1:WORD_W] <= cfg_wdata[HI_W-1:0];
         else if (wr && a == OFF_LO)
            ptr_q[WORD_W-1:0] <= cfg_wdata;
      end
      assign list_ptr[i] = ptr_q;
   end

   assign strobe     = cfg_valid && (a == OFF_RST0 || a == OFF_RST1);
   assign strobe_sel = (a == OFF_RST1);
endmodule

// File: rtl/dle_sequencer.sv
module dle_sequencer
   import dle_pkg::*;
#(
   parameter int                ADDR_W    = 20,
   parameter bit                PROTECT   = 1'b1,
   parameter logic [REG_AW-1:0] PROT_LOW  = 9'h010,
   parameter logic [REG_AW-1:0] PROT_HIGH = 9'h020
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic                   restart,
   input  logic                   restart_sel,
   input  logic [1:0][ADDR_W-1:0] list_ptr,
   input  logic                   guard_off,
   input  logic                   slot_grant,
   input  logic [WORD_W-1:0]      pos,
   input  logic [WORD_W-1:0]      mem_rdata,
   output logic                   mem_req,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   rw_valid,
   output logic [REG_AW-1:0]      rw_addr,
   output logic [WORD_W-1:0]      rw_data
);
   dle_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] ir0_q, wmask_q, wref_q;
   logic              skip_q;

   logic [WORD_W-1:0] new_mask, new_ref;
   logic [REG_AW-1:0] mv_addr;
   logic              blocked;
   logic [1:0]        hit;

   assign new_mask = FIXED_CMP_BITS | (mem_rdata & MASK_FIELD);
   assign new_ref  = ir0_q & new_mask;
   assign mv_addr  = ir0_q[REG_AW-1:0] & REG_ALIGN;

   // site 0: pending wait, site 1: skip being decoded
   for (genvar s = 0; s < 2; s++) begin : g_cmp
      dle_beam_cmp u_cmp (
         .pos     (pos),
         .mask    (s == 0 ? wmask_q : new_mask),
         .ref_val (s == 0 ? wref_q  : new_ref),
         .reached (hit[s])
      );
   end

   if (PROTECT) begin : g_guard
      assign blocked = (mv_addr < PROT_LOW) || ((mv_addr < PROT_HIGH) && !guard_off);
   end else begin : g_noguard
      assign blocked = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_STOP;
         addr_q   <= '0;
         ir0_q    <= '0;
         wmask_q  <= '0;
         wref_q   <= '0;
         skip_q   <= 1'b0;
         rw_valid <= 1'b0;
         rw_addr  <= '0;
         rw_data  <= '0;
      end else begin
         rw_valid <= 1'b0;
         if (!run) begin
            state <= ST_STOP;
         end else if (restart) begin
            state  <= ST_FETCH_A;
            addr_q <= restart_sel ? list_ptr[1] : list_ptr[0];
            skip_q <= 1'b0;
         end else if (slot_grant) begin
            unique case (state)
               ST_WAIT: begin
                  if (hit[0]) state <= ST_FETCH_A;
               end
               ST_FETCH_A: begin
                  ir0_q  <= mem_rdata;
                  addr_q <= addr_q + 1'b1;
                  state  <= ST_FETCH_B;
               end
               ST_FETCH_B: begin
                  addr_q <= addr_q + 1'b1;
                  skip_q <= 1'b0;
                  if (!ir0_q[0]) begin
                     state <= ST_FETCH_A;
                     if (!skip_q) begin
                        if (blocked) begin
                           state <= ST_STOP;
                        end else begin
                           rw_valid <= 1'b1;
                           rw_addr  <= mv_addr;
                           rw_data  <= mem_rdata;
                        end
                     end
                  end else if (!mem_rdata[0]) begin
                     wmask_q <= new_mask;
                     wref_q  <= new_ref;
                     state   <= ST_WAIT;
                  end else begin
                     skip_q <= hit[1];
                     state  <= ST_FETCH_A;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign mem_req  = run && (state == ST_FETCH_A || state == ST_FETCH_B);
   assign mem_addr = addr_q;
endmodule

// File: rtl/dlist_engine.sv
module dlist_engine
   import dle_pkg::*;
#(
   parameter int                ADDR_W    = 20,
   parameter bit                PROTECT   = 1'b1,
   parameter logic [REG_AW-1:0] PROT_LOW  = 9'h010,
   parameter logic [REG_AW-1:0] PROT_HIGH = 9'h020
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 master_dma_en,
   input  logic                 list_dma_en,
   input  logic                 frame_start,
   input  logic [7:0]           beam_v,
   input  logic [6:0]           beam_hc,
   input  logic                 cfg_valid,
   input  logic                 cfg_write,
   input  logic [REG_AW-1:0]    cfg_addr,
   input  logic [WORD_W-1:0]    cfg_wdata,
   input  logic                 slot_grant,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic [WORD_W-1:0]    mem_rdata,
   output logic                 rw_valid,
   output logic [REG_AW-1:0]    rw_addr,
   output logic [WORD_W-1:0]    rw_data
);
   if (ADDR_W < WORD_W + 1 || ADDR_W > 2 * WORD_W) begin : g_bad_addr_w
      $error("dlist_engine: ADDR_W must lie in 17..32");
   end
   if (PROT_LOW > PROT_HIGH) begin : g_bad_prot
      $error("dlist_engine: PROT_LOW above PROT_HIGH");
   end

   logic                   run, strobe, strobe_sel, guard_off;
   logic [1:0][ADDR_W-1:0] list_ptr;
   logic [WORD_W-1:0]      pos;

   assign run = master_dma_en && list_dma_en;
   assign pos = {beam_v, beam_hc, 1'b0};

   dle_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_valid  (cfg_valid),
      .cfg_write  (cfg_write),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .guard_off  (guard_off),
      .list_ptr   (list_ptr),
      .strobe     (strobe),
      .strobe_sel (strobe_sel)
   );

   dle_sequencer #(
      .ADDR_W    (ADDR_W),
      .PROTECT   (PROTECT),
      .PROT_LOW  (PROT_LOW),
      .PROT_HIGH (PROT_HIGH)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .restart     (strobe || frame_start),
      .restart_sel (strobe && strobe_sel),
      .list_ptr    (list_ptr),
      .guard_off   (guard_off),
      .slot_grant  (slot_grant),
      .pos         (pos),
      .mem_rdata   (mem_rdata),
      .mem_req     (mem_req),
      .mem_addr    (mem_addr),
      .rw_valid    (rw_valid),
      .rw_addr     (rw_addr),
      .rw_data     (rw_data)
   );
endmodule

// File: rtl/dle_chk.sv
module dle_chk
   import dle_pkg::*;
#(
   parameter int                ADDR_W   = 20,
   parameter logic [REG_AW-1:0] PROT_LOW = 9'h010
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_dma_en,
   input logic              list_dma_en,
   input logic              frame_start,
   input logic              cfg_valid,
   input logic [REG_AW-1:0] cfg_addr,
   input logic              slot_grant,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              rw_valid,
   input logic [REG_AW-1:0] rw_addr
);
   logic run_c, strobe_c, rst_any;
   assign run_c    = master_dma_en && list_dma_en;
   assign strobe_c = cfg_valid && ((cfg_addr & REG_ALIGN) == OFF_RST0 ||
                                   (cfg_addr & REG_ALIGN) == OFF_RST1);
   assign rst_any  = strobe_c || frame_start;

   // R8
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_c |=> (!mem_req && !rw_valid));

   // R1
   move_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rw_valid |-> $past(slot_grant && mem_req));

   // R5
   move_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rw_valid |-> (rw_addr >= PROT_LOW && !rw_addr[0]));

   // R1
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_grant && mem_req && run_c && !rst_any) |=> mem_addr == $past(mem_addr) + 1'b1);

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(slot_grant && mem_req) && !rst_any) |=> $stable(mem_addr));

   // R6
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_c && rst_any) |=> mem_req);
endmodule

bind dlist_engine dle_chk #(.ADDR_W(ADDR_W), .PROT_LOW(PROT_LOW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .master_dma_en (master_dma_en),
   .list_dma_en   (list_dma_en),
   .frame_start   (frame_start),
   .cfg_valid     (cfg_valid),
   .cfg_addr      (cfg_addr),
   .slot_grant    (slot_grant),
   .mem_req       (mem_req),
   .mem_addr      (mem_addr),
   .rw_valid      (rw_valid),
   .rw_addr       (rw_addr)
);

// File: tb/sim_dlist_engine.sv
`timescale 1ns/1ps
module sim_dlist_engine;
   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          master_dma_en = 1'b1, list_dma_en = 1'b1, frame_start = 1'b0;
   logic [7:0]    beam_v = '0;
   logic [6:0]    beam_hc = '0;
   logic          cfg_valid = 1'b0, cfg_write = 1'b0;
   logic [8:0]    cfg_addr = '0;
   logic [15:0]   cfg_wdata = '0;
   logic          slot_grant = 1'b0;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic [15:0]   mem_rdata;
   logic          rw_valid;
   logic [8:0]    rw_addr;
   logic [15:0]   rw_data;

   logic [15:0] mem [256];
   assign mem_rdata = mem[mem_addr[7:0]];

   always #2 clk = ~clk;

   dlist_engine #(.ADDR_W(AW)) u0 (.*);

   int n_chk = 0, n_bad = 0, wr_cnt = 0;
   logic [8:0]  wa [64];
   logic [15:0] wd [64];

   always @(negedge clk) if (rw_valid && rst_n) begin
      wa[wr_cnt[5:0]] = rw_addr;
      wd[wr_cnt[5:0]] = rw_data;
      wr_cnt++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(input int a, input logic [15:0] w0, input logic [15:0] w1);
      mem[a] = w0; mem[a+1] = w1;
   endtask

   task automatic park(input int a);
      put(a, 16'hFFFF, 16'hFFFE);
   endtask

   task automatic cfg(input logic [8:0] a, input logic [15:0] d, input logic w);
      cfg_valid = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_write = w;
      @(negedge clk);
      cfg_valid = 1'b0; cfg_write = 1'b0;
   endtask

   task automatic set_ptr(input int idx, input logic [31:0] p);
      cfg(9'h080 + 9'(4*idx), p[31:16], 1'b1);
      cfg(9'h082 + 9'(4*idx), p[15:0], 1'b1);
   endtask

   task automatic grants(input int k);
      repeat (k) begin
         slot_grant = 1'b1; @(negedge clk);
         slot_grant = 1'b0; @(negedge clk);
      end
   endtask

   task automatic chk_wr(input string req, input int base, input int i,
                         input logic [8:0] a, input logic [15:0] d);
      chk(req, {7'd0, wa[(base+i)%64], wd[(base+i)%64]}, {7'd0, a, d});
   endtask

   task automatic t_reset;
      chk("R10 mem_req", mem_req, 0);
      chk("R10 rw_valid", rw_valid, 0);
      chk("R10 mem_addr", mem_addr, 0);
   endtask

   task automatic t_move;
      int b;
      put(16'h10, 16'hFF82, 16'h0ABC); put(16'h12, 16'h0180, 16'h1234); park(16'h14);
      set_ptr(0, 32'h10);
      b = wr_cnt;
      cfg(9'h088, 16'h0, 1'b1);
      chk("R6 restart list 1 addr", mem_addr, 32'h10);
      chk("R6 restart req", mem_req, 1);
      grants(20);
      chk("R1 store count", wr_cnt - b, 2);
      chk_wr("R1 first store masked", b, 0, 9'h182, 16'h0ABC);
      chk_wr("R1 second store", b, 1, 9'h180, 16'h1234);
      chk("R2 wait no request", mem_req, 0);
      chk("R1 address after list", mem_addr, 32'h16);
   endtask

   task automatic t_wait;
      int b;
      put(16'h30, 16'h4001, 16'hFF00); put(16'h32, 16'h0190, 16'h5555); park(16'h34);
      set_ptr(0, 32'h30);
      beam_v = 8'h3F; b = wr_cnt;
      cfg(9'h088, 16'h0, 1'b1);
      grants(20);
      chk("R2 held below compare", wr_cnt - b, 0);
      beam_v = 8'h40;
      grants(20);
      chk("R3 exact beam does not release", wr_cnt - b, 0);
      beam_v = 8'h41;
      grants(20);
      chk("R2 released past compare", wr_cnt - b, 1);
      chk_wr("R2 store after wait", b, 0, 9'h190, 16'h5555);
   endtask

   task automatic t_fixed_bit;
      int b;
      put(16'h40, 16'h0001, 16'h0000); put(16'h42, 16'h0192, 16'h0042); park(16'h44);
      set_ptr(0, 32'h40);
      beam_v = 8'h7F; beam_hc = 7'h7F; b = wr_cnt;
      cfg(9'h088, 16'h0, 1'b1);
      grants(20);
      chk("R3 unmasked bits ignored", wr_cnt - b, 0);
      beam_v = 8'h80; beam_hc = 7'h00;
      grants(20);
      chk("R3 bit 15 always compared", wr_cnt - b, 1);
   endtask

   task automatic t_skip;
      int b;
      put(16'h50, 16'h2001, 16'hFF01); put(16'h52, 16'h0180, 16'h0001);
      put(16'h54, 16'h0182, 16'h0002); park(16'h56);
      set_ptr(0, 32'h50);
      beam_v = 8'h30; b = wr_cnt;
      cfg(9'h088, 16'h0, 1'b1);
      grants(20);
      chk("R4 skip taken count", wr_cnt - b, 1);
      chk_wr("R4 skip taken target", b, 0, 9'h182, 16'h0002);
      beam_v = 8'h10; b = wr_cnt;
      cfg(9'h088, 16'h0, 1'b1);
      grants(20);
      chk("R4 skip not taken count", wr_cnt - b, 2);
      chk_wr("R4 skip not taken first", b, 0, 9'h180, 16'h0001);
   endtask

   task automatic t_protect;
      int b;
      put(16'h60, 16'h0180, 16'h0007); put(16'h62, 16'h001E, 16'h0009);
      put(16'h64, 16'h0182, 16'h0008); park(16'h66);
      put(16'h70, 16'h000E, 16'h0003); put(16'h72, 16'h0180, 16'h0004); park(16'h74);
      set_ptr(0, 32'h60);
      cfg(9'h02E, 16'h0000, 1'b1);
      b = wr_cnt;
      cfg(9'h088, 16'h0, 1'b1);
      grants(20);
      chk("R5 halt below 0x20 guarded", wr_cnt - b, 1);
      chk("R5 halted no request", mem_req, 0);
      chk("R5 halted address", mem_addr, 32'h64);
      cfg(9'h02E, 16'h0001, 1'b1);
      b = wr_cnt;
      cfg(9'h088, 16'h0, 1'b1);
      grants(20);
      chk("R5 guard off allows 0x1E", wr_cnt - b, 3);
      chk_wr("R5 guarded store", b, 1, 9'h01E, 16'h0009);
      set_ptr(0, 32'h70);
      b = wr_cnt;
      cfg(9'h088, 16'h0, 1'b1);
      grants(20);
      chk("R5 below 0x10 always halts", wr_cnt - b, 0);
      cfg(9'h02E, 16'h0000, 1'b1);
   endtask

   task automatic t_lists;
      int b;
      put(16'h80, 16'h0184, 16'h0077); park(16'h82);
      set_ptr(1, 32'h80);
      set_ptr(0, 32'h10);
      b = wr_cnt;
      cfg(9'h08A, 16'h0, 1'b0);
      chk("R6 read strobe list 2", mem_addr, 32'h80);
      grants(20);
      chk_wr("R6 list 2 store", b, 0, 9'h184, 16'h0077);
      b = wr_cnt;
      frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
      chk("R7 frame restarts list 1", mem_addr, 32'h10);
      grants(20);
      chk("R7 frame list 1 stores", wr_cnt - b, 2);
      frame_start = 1'b1;
      cfg(9'h08A, 16'h0, 1'b1);
      frame_start = 1'b0;
      chk("R7 strobe wins over frame", mem_addr, 32'h80);
      grants(10);
   endtask

   task automatic t_dma;
      int b;
      set_ptr(0, 32'h30);
      beam_v = 8'h3F; b = wr_cnt;
      cfg(9'h088, 16'h0, 1'b1);
      grants(20);
      master_dma_en = 1'b0;
      @(negedge clk);
      chk("R8 disabled no request", mem_req, 0);
      cfg(9'h088, 16'h0, 1'b1);
      chk("R8 restart ignored while off", mem_req, 0);
      master_dma_en = 1'b1; beam_v = 8'h41;
      grants(20);
      chk("R8 stays stopped", wr_cnt - b, 0);
      cfg(9'h088, 16'h0, 1'b1);
      grants(20);
      chk("R8 runs after restart", wr_cnt - b, 1);
   endtask

   task automatic t_skip_clear;
      int b;
      put(16'h90, 16'h2001, 16'hFF01); put(16'h92, 16'h0186, 16'h0066); park(16'h94);
      put(16'hA0, 16'h0188, 16'h0099); park(16'hA2);
      set_ptr(0, 32'h90); set_ptr(1, 32'hA0);
      beam_v = 8'h30; b = wr_cnt;
      cfg(9'h088, 16'h0, 1'b1);
      grants(2);
      cfg(9'h08A, 16'h0, 1'b1);
      grants(20);
      chk("R9 restart clears skip", wr_cnt - b, 1);
      chk_wr("R9 store after restart", b, 0, 9'h188, 16'h0099);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_move();
      t_wait();
      t_fixed_bit();
      t_skip();
      t_protect();
      t_lists();
      t_dma();
      t_skip_clear();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule